// File: doc/BRIEF.md
# Window Watchdog with Initial Phase

This block is a supervisory timer that counts pulses of a slow tick input and raises a reset pulse when software fails to service it correctly. After reset it runs an initial phase with a fixed timeout and no window. In this phase the window length can be configured, and the first service key must arrive before the timeout.

Once the first key is accepted, the block runs windowed periods. Each period starts with a closed half, in which any service write is a fault. The closed half is followed by an open half, in which the next key of an alternating pair must arrive.

A debug-disable input switches the watchdog off and restarts the initial phase when it is released. A low-power input freezes the count and rearms the key sequence.

Top module: `wwdg_top`

## Requirements
- R1: After `rst`, after every watchdog reset pulse and after `dbg_off_i` is released, the block is in the initial phase. In this phase `win_open_o`=1, `wd_rst_o`=0 and the expected key is 0xAA.
- R2: In the initial phase, if no correct key arrives, `wd_rst_o` rises one clock after the INIT_TICKS-th tick (counted from phase entry) has been sampled.
- R3: A service write (`wr_en_i`=1, `wr_sel_i`=0) of 0xAA in the initial phase enters the closed half on the next clock, with `win_open_o`=0 and the tick count restarted. Any other value starts a reset pulse instead. A correct key in the same cycle as the final tick wins over the timeout.
- R4: A configuration write (`wr_en_i`=1, `wr_sel_i`=1) in the initial phase stores `wr_data_i[2:0]` as a code n. Each half of the window then lasts UNIT_TICKS·2^n/2 ticks. The write does not change the initial timeout.
- R5: Configuration writes in the closed or open half are ignored: they neither reset the block nor change the window length.
- R6: In the closed half, any service write starts a reset pulse. After half a period of ticks, the block enters the open half, with `win_open_o`=1.
- R7: In the open half, the expected key restarts the period in the closed half. Keys alternate 0x55, 0xAA, 0x55 and so on after the first 0xAA. A wrong value starts a reset pulse, and a correct key wins over a coincident final tick.
- R8: If the open half reaches its last tick without a correct key, a reset pulse starts on the next clock.
- R9: `wd_rst_o` stays high for exactly RST_CLKS clocks. It then drops and the block is in the initial phase, with the configuration code retained.
- R10: While `dbg_off_i`=1 and no pulse is running, `wd_off_o`=1, `win_open_o`=0, writes are ignored and no reset is produced.
- R11: While `lowpwr_i`=1, `wd_off_o`=1, `win_open_o`=0, ticks are not counted, writes are ignored and the expected key returns to 0xAA. On release, the phase and count resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tick_i | input | 1 | one-clock time base pulse |
| wr_en_i | input | 1 | register write strobe |
| wr_sel_i | input | 1 | 0 = service key, 1 = window configuration |
| wr_data_i | input | 8 | write data |
| dbg_off_i | input | 1 | debug disable |
| lowpwr_i | input | 1 | low-power freeze |
| win_open_o | output | 1 | service currently allowed |
| wd_off_o | output | 1 | watchdog inactive |
| wd_rst_o | output | 1 | watchdog reset pulse |

## Verification
The bench drives tick streams at full rate and at one tick per three clocks. It uses both short and long window codes, so that the half-period length is told apart from the initial timeout.

Key sequences cover a correct alternation, a wrong key in each phase, a write in the closed half and a lapse of the open half. Together these separate the closed-half faults from the open-half faults and from the timeouts.

Debug and low-power episodes placed mid-window distinguish a restart from a frozen resume and show that the key rearms. Configuration writes after the initial phase confirm that the window length is unchanged.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
  typedef enum logic [1:0] {PH_INIT, PH_CLOSED, PH_OPEN, PH_PULSE} phase_e;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wwdg_window_cfg.sv
module wwdg_window_cfg #(
  parameter int UNIT_TICKS = 10,
  parameter int CODE_W     = 3,
  parameter int CW         = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CODE_W-1:0] code_in,
  output logic [CW-1:0]     half_ticks
);
  localparam int NCODES = 1 << CODE_W;

  logic [CODE_W-1:0] code_q;
  logic [CW-1:0]     lut [NCODES];

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else if (we) code_q <= code_in;
  end

  for (genvar g = 0; g < NCODES; g++) begin : g_lut
    assign lut[g] = CW'((UNIT_TICKS << g) / 2);
  end

  assign half_ticks = lut[code_q];

  // R5: the code only moves on an enabled write
  p_cfg_locked_r5: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(code_q));
endmodule

// File: rtl/wwdg_tickcnt.sv
module wwdg_tickcnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          hold,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (tick && !hold) cnt <= cnt + 1'b1;
  end

  assign last = tick && !hold && (cnt == limit - 1'b1);

  // R11: a held counter keeps its value
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (hold && !clr) |=> $stable(cnt));
endmodule

// File: rtl/wwdg_keyseq.sv
module wwdg_keyseq
  import wwdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       advance,
  output logic [7:0] expect_key
);
  logic second_q;

  always_ff @(posedge clk) begin
    if (rst) second_q <= 1'b0;
    else if (restart) second_q <= 1'b0;
    else if (advance) second_q <= ~second_q;
  end

  assign expect_key = second_q ? KEY_SECOND : KEY_FIRST;

  // R7: each accepted key flips the expected one
  p_key_toggles_r7: assert property (@(posedge clk) disable iff (rst)
    (advance && !restart) |=> (expect_key != $past(expect_key)));
endmodule

// File: rtl/wwdg_ctrl.sv
module wwdg_ctrl
  import wwdg_pkg::*;
#(
  parameter int RST_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       last,
  input  logic       svc_wr,
  input  logic       cfg_wr,
  input  logic [7:0] wr_data,
  input  logic [7:0] expect_key,
  input  logic       dbg_off,
  input  logic       lowpwr,
  output phase_e     phase,
  output logic       cnt_clr,
  output logic       cnt_hold,
  output logic       key_restart,
  output logic       key_advance,
  output logic       cfg_we,
  output logic       win_open_o,
  output logic       wd_off_o,
  output logic       wd_rst_o
);
  localparam int PW = $clog2(RST_CLKS + 1);

  phase_e        ph_q, nxt;
  logic [PW-1:0] pcnt;
  logic          key_ok;

  assign key_ok   = (wr_data == expect_key);
  assign cnt_hold = (ph_q == PH_PULSE) || lowpwr || dbg_off;
  assign phase    = ph_q;

  always_comb begin
    nxt         = ph_q;
    cnt_clr     = 1'b0;
    key_restart = 1'b0;
    key_advance = 1'b0;
    cfg_we      = 1'b0;
    if (ph_q == PH_PULSE) begin
      if (pcnt == PW'(RST_CLKS - 1)) begin
        nxt         = PH_INIT;
        cnt_clr     = 1'b1;
        key_restart = 1'b1;
      end
    end else if (dbg_off) begin
      nxt         = PH_INIT;
      cnt_clr     = 1'b1;
      key_restart = 1'b1;
    end else if (lowpwr) begin
      key_restart = 1'b1;
    end else begin
      case (ph_q)
        PH_INIT: begin
          cfg_we = cfg_wr;
          if (svc_wr) begin
            if (key_ok) begin
              nxt         = PH_CLOSED;
              cnt_clr     = 1'b1;
              key_advance = 1'b1;
            end else begin
              nxt = PH_PULSE;
            end
          end else if (last) begin
            nxt = PH_PULSE;
          end
        end
        PH_CLOSED: begin
          if (svc_wr) nxt = PH_PULSE;
          else if (last) begin
            nxt     = PH_OPEN;
            cnt_clr = 1'b1;
          end
        end
        PH_OPEN: begin
          if (svc_wr) begin
            if (key_ok) begin
              nxt         = PH_CLOSED;
              cnt_clr     = 1'b1;
              key_advance = 1'b1;
            end else begin
              nxt = PH_PULSE;
            end
          end else if (last) begin
            nxt = PH_PULSE;
          end
        end
        default: nxt = PH_INIT;
      endcase
      if (nxt == PH_PULSE) cnt_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_INIT;
      pcnt       <= '0;
      win_open_o <= 1'b1;
      wd_off_o   <= 1'b0;
      wd_rst_o   <= 1'b0;
    end else begin
      ph_q       <= nxt;
      pcnt       <= (ph_q == PH_PULSE && nxt == PH_PULSE) ? pcnt + 1'b1 : '0;
      win_open_o <= !(dbg_off || lowpwr) && (nxt == PH_INIT || nxt == PH_OPEN);
      wd_off_o   <= dbg_off || lowpwr;
      wd_rst_o   <= (nxt == PH_PULSE);
    end
  end

  // R6: a write in the closed half ends in a reset pulse
  p_closed_write_r6: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_CLOSED && svc_wr && !dbg_off && !lowpwr) |=> wd_rst_o);
  // R10: debug disable forces the initial phase with the block off
  p_dbg_init_r10: assert property (@(posedge clk) disable iff (rst)
    (dbg_off && ph_q != PH_PULSE) |=> (ph_q == PH_INIT && wd_off_o && !win_open_o));
  // R9: the pulse always hands over to the initial phase
  p_pulse_to_init_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_rst_o) |-> (ph_q == PH_INIT));
  // R1: never open while a reset pulse is out
  p_no_open_in_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    wd_rst_o |-> !win_open_o);
endmodule

// File: rtl/wwdg_top.sv
module wwdg_top
  import wwdg_pkg::*;
#(
  parameter int UNIT_TICKS = 10,
  parameter int CODE_W     = 3,
  parameter int INIT_TICKS = 256,
  parameter int RST_CLKS   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       dbg_off_i,
  input  logic       lowpwr_i,
  output logic       win_open_o,
  output logic       wd_off_o,
  output logic       wd_rst_o
);
  localparam int MAX_WIN = (UNIT_TICKS << ((1 << CODE_W) - 1)) / 2;
  localparam int MAXT    = (INIT_TICKS > MAX_WIN) ? INIT_TICKS : MAX_WIN;
  localparam int CW      = $clog2(MAXT + 1);

  phase_e        phase;
  logic          last, cnt_clr, cnt_hold, key_restart, key_advance, cfg_we;
  logic [7:0]    expect_key;
  logic [CW-1:0] half_ticks, limit;

  assign limit = (phase == PH_INIT) ? CW'(INIT_TICKS) : half_ticks;

  wwdg_window_cfg #(.UNIT_TICKS(UNIT_TICKS), .CODE_W(CODE_W), .CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .code_in(wr_data_i[CODE_W-1:0]),
    .half_ticks(half_ticks));

  wwdg_tickcnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .hold(cnt_hold), .clr(cnt_clr),
    .limit(limit), .last(last));

  wwdg_keyseq u_key (
    .clk(clk), .rst(rst), .restart(key_restart), .advance(key_advance),
    .expect_key(expect_key));

  wwdg_ctrl #(.RST_CLKS(RST_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .last(last),
    .svc_wr(wr_en_i && !wr_sel_i), .cfg_wr(wr_en_i && wr_sel_i),
    .wr_data(wr_data_i), .expect_key(expect_key),
    .dbg_off(dbg_off_i), .lowpwr(lowpwr_i), .phase(phase),
    .cnt_clr(cnt_clr), .cnt_hold(cnt_hold), .key_restart(key_restart),
    .key_advance(key_advance), .cfg_we(cfg_we),
    .win_open_o(win_open_o), .wd_off_o(wd_off_o), .wd_rst_o(wd_rst_o));
endmodule

// File: tb/sim_wwdg_top.sv
module sim_wwdg_top;
  localparam int UNIT = 4;
  localparam int INIT = 20;
  localparam int RSTC = 3;

  logic clk = 1'b0, rst = 1'b1, tick_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic dbg_off_i = 1'b0, lowpwr_i = 1'b0;
  logic win_open_o, wd_off_o, wd_rst_o;

  int total = 0, bad = 0, tick_every = 1, tdiv = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wwdg_top #(.UNIT_TICKS(UNIT), .CODE_W(3), .INIT_TICKS(INIT), .RST_CLKS(RSTC)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .dbg_off_i(dbg_off_i), .lowpwr_i(lowpwr_i),
    .win_open_o(win_open_o), .wd_off_o(wd_off_o), .wd_rst_o(wd_rst_o));

  always @(negedge clk) begin
    tdiv = (tdiv + 1 >= tick_every) ? 0 : tdiv + 1;
    tick_i <= (tdiv == 0);
  end

  // behavioural model: phase 0 init, 1 closed, 2 open, 3 pulse
  int m_ph = 0, m_cnt = 0, m_pc = 0, m_cfg = 0;
  bit m_second = 0, m_wo = 1, m_off = 0, m_rst = 0;

  always @(posedge clk) begin
    int lim, nph;
    bit hold, expire, svc, good, clr;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_pc = 0; m_cfg = 0; m_second = 0;
      m_wo = 1; m_off = 0; m_rst = 0;
    end else begin
      lim    = (m_ph == 0) ? INIT : (UNIT << m_cfg) / 2;
      hold   = (m_ph == 3) || lowpwr_i || dbg_off_i;
      expire = tick_i && !hold && (m_cnt == lim - 1);
      svc    = wr_en_i && !wr_sel_i;
      good   = (wr_data_i == (m_second ? 8'h55 : 8'hAA));
      nph = m_ph; clr = 0;
      if (m_ph == 3) begin
        if (m_pc == RSTC - 1) begin nph = 0; clr = 1; m_second = 0; end
      end else if (dbg_off_i) begin
        nph = 0; clr = 1; m_second = 0;
      end else if (lowpwr_i) begin
        m_second = 0;
      end else begin
        if (m_ph == 0 && wr_en_i && wr_sel_i) m_cfg = int'(wr_data_i[2:0]);
        if (m_ph == 1) begin
          if (svc) nph = 3;
          else if (expire) begin nph = 2; clr = 1; end
        end else begin
          if (svc) begin
            if (good) begin nph = 1; clr = 1; m_second = !m_second; end
            else nph = 3;
          end else if (expire) nph = 3;
        end
        if (nph == 3) clr = 1;
      end
      if (clr) m_cnt = 0;
      else if (tick_i && !hold) m_cnt = m_cnt + 1;
      m_pc = (m_ph == 3 && nph == 3) ? m_pc + 1 : 0;
      m_ph  = nph;
      m_rst = (m_ph == 3);
      m_off = dbg_off_i || lowpwr_i;
      m_wo  = !m_off && (m_ph == 0 || m_ph == 2);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (win_open_o !== m_wo || wd_off_o !== m_off || wd_rst_o !== m_rst) begin
        bad++;
        $display("FAIL %s t=%0t open/off/rst got %b%b%b exp %b%b%b", cur_req, $time,
                 win_open_o, wd_off_o, wd_rst_o, m_wo, m_off, m_rst);
      end
    end
  end

  task automatic chk(input bit got, input bit expv, input string what);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s %s got %b exp %b", cur_req, what, got, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_for(input bit open_v, input bit rst_v);
    for (int i = 0; i < 3000; i++) begin
      if (win_open_o == open_v && wd_rst_o == rst_v) return;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(1);
  endtask

  initial begin
    idle(3); rst = 1'b0; idle(1);
    cur_req = "R1";
    chk(win_open_o, 1'b1, "open after reset");
    chk(wd_rst_o, 1'b0, "no pulse after reset");
    chk(wd_off_o, 1'b0, "on after reset");

    cur_req = "R2"; wait_for(1'b0, 1'b1); chk(wd_rst_o, 1'b1, "init timeout pulse");
    cur_req = "R9"; idle(RSTC); chk(wd_rst_o, 1'b0, "pulse length"); chk(win_open_o, 1'b1, "back to init");

    cur_req = "R3"; do_reset(); wr(1'b0, 8'h55); chk(wd_rst_o, 1'b1, "wrong first key");
    idle(RSTC + 1);
    wr(1'b0, 8'hAA); chk(win_open_o, 1'b0, "AA enters closed");

    cur_req = "R4"; do_reset(); wr(1'b1, 8'h01); wr(1'b0, 8'hAA);
    wait_for(1'b1, 1'b0); chk(win_open_o, 1'b1, "open after half");
    cur_req = "R7"; wr(1'b0, 8'h55); chk(win_open_o, 1'b0, "55 accepted");
    cur_req = "R5"; wr(1'b1, 8'h07); chk(wd_rst_o, 1'b0, "cfg write ignored");
    cur_req = "R7"; wait_for(1'b1, 1'b0); wr(1'b0, 8'hAA); chk(wd_rst_o, 1'b0, "AA accepted");
    cur_req = "R8"; wait_for(1'b0, 1'b1); chk(wd_rst_o, 1'b1, "open half lapse");
    idle(RSTC + 1);

    cur_req = "R6"; wr(1'b0, 8'hAA); idle(1); wr(1'b0, 8'h55); chk(wd_rst_o, 1'b1, "closed write");
    idle(RSTC + 1);

    cur_req = "R7"; wr(1'b0, 8'hAA); wait_for(1'b1, 1'b0); wr(1'b0, 8'hAA);
    chk(wd_rst_o, 1'b1, "wrong alternate key");
    idle(RSTC + 1);

    cur_req = "R10"; tick_every = 3; wr(1'b0, 8'hAA); idle(2);
    @(negedge clk); dbg_off_i = 1'b1; idle(2);
    chk(wd_off_o, 1'b1, "off flag"); wr(1'b0, 8'h12); chk(wd_rst_o, 1'b0, "write ignored");
    idle(60); chk(wd_rst_o, 1'b0, "no timeout while off");
    @(negedge clk); dbg_off_i = 1'b0; idle(1); chk(win_open_o, 1'b1, "restart init");

    cur_req = "R11"; wr(1'b0, 8'hAA); wait_for(1'b1, 1'b0); wr(1'b0, 8'h55);
    wait_for(1'b1, 1'b0);
    @(negedge clk); lowpwr_i = 1'b1; idle(40);
    chk(wd_off_o, 1'b1, "lp off flag"); chk(wd_rst_o, 1'b0, "lp frozen");
    @(negedge clk); lowpwr_i = 1'b0; idle(1);
    chk(win_open_o, 1'b1, "lp resumes open");
    wr(1'b0, 8'hAA); chk(wd_rst_o, 1'b0, "key rearmed to AA");

    cur_req = "R4"; do_reset(); tick_every = 1; wr(1'b1, 8'h07);
    wait_for(1'b0, 1'b1); chk(wd_rst_o, 1'b1, "init timeout unchanged");
    idle(RSTC + 1);
    tick_every = 3; wr(1'b0, 8'hAA);
    for (int k = 0; k < 3; k++) begin
      wait_for(1'b1, 1'b0); wr(1'b0, (k % 2 == 0) ? 8'h55 : 8'hAA);
    end
    chk(wd_rst_o, 1'b0, "long window sequence");
    idle(5);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; total++; bad++;
      $display("FAIL %s watchdog expired got 0 exp 1", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule